// File: doc/BRIEF.md
# Four-Way Exact Recency Replacement Tracker

This block holds the replacement state of a four-way set-associative cache. For every set it keeps an exact ordering of the four ways, from the most recently touched to the least recently touched. The order is stored as a two-bit age per way: age 0 is the newest way and age 3 is the oldest. Tag matching, data arrays and refill traffic live outside the block. The surrounding cache controller reports each access as a single strobe that names a set and a way. A hit reports the way that matched. A fill reports the way that was just written. Both update the order in the same way.

A second, independent port reads back one set. The controller drives a query set index together with that set's four valid bits. The block then returns the set's four ages and the way to evict. An empty way is always evicted before any occupied way, and the lowest-numbered empty way is taken first. When every way is occupied, the way with age 3 is evicted. The number of sets is a parameter. The state update takes one clock. The victim and the ages are combinational from the stored state and the query inputs.

Top module: `lru_tracker`

## Requirements
- R1: While reset is asserted and just after it is released, every set reports age 0 for way 0, age 1 for way 1, age 2 for way 2 and age 3 for way 3. On `query_age`, way w's age is at bits [2w+1:2w].
- R2: An access strobe on a set and way gives that way age 0 in that set from the next clock edge.
- R3: In the accessed set, every other way whose age was lower than the accessed way's old age has its age raised by one.
- R4: In the accessed set, every other way whose age was higher than the accessed way's old age keeps its age.
- R5: The four ages of any set are always four distinct values from 0 to 3.
- R6: When all four query valid bits are 1, `victim_way` is the index of the way whose age is 3.
- R7: When any query valid bit is 0, `victim_way` is the lowest index whose valid bit is 0, whatever the ages are.
- R8: An access changes no set other than the one it names.
- R9: A cycle without an access strobe changes no set.
- R10: Start with the set empty. Fill A, C, B and D, and on each miss fill the reported victim. Then E is filled into the way that A held. A later hit on B leaves B at age 0 and E at age 1.
- R11: Repeat five distinct blocks in a cycle through one set, filling the reported victim on each miss. This gives no hits at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe: a hit or a fill happened this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way that was hit or filled |
| query_set | input | SET_W | Set index whose state is read back |
| query_valid | input | 4 | Valid bits of the queried set's ways, bit w for way w |
| query_age | output | 8 | Ages of the queried set, way w at bits [2w+1:2w] |
| victim_way | output | 2 | Way to evict in the queried set |

## Verification
Several properties are checked on every cycle for whichever set is being queried. The four ages must stay a permutation. A touched way must show age 0 on the next cycle. A set that nothing touches must hold its state. The victim must follow the empty-first rule and then the oldest-way rule. Other behaviour can only be seen in the bench's scenarios. This covers the exact ageing of the other ways after each access, against an independent ordered-list model, over a long pseudo-random access stream. It also covers the full victim sweep over all sixteen valid masks, the named fill/hit sequence, and the zero-hit result of cycling five blocks through one set.

// File: rtl/lru_pkg.sv
package lru_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0]            way_t;
    typedef logic [AGE_W-1:0]            age_t;
    typedef logic [WAYS-1:0][AGE_W-1:0]  age_vec_t;
    typedef logic [WAYS-1:0]             valid_vec_t;

    // Ages of a set after reset: way index equals its age.
    function automatic age_vec_t reset_ages();
        age_vec_t v;
        for (int w = 0; w < WAYS; w++) begin
            v[w] = AGE_W'(w);
        end
        return v;
    endfunction
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update
    import lru_pkg::*;
(
    input  age_vec_t cur_ages,
    input  way_t     touch_way,
    output age_vec_t nxt_ages
);
    age_t touched_age;

    always_comb begin
        touched_age = cur_ages[touch_way];
    end

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_way
        always_comb begin
            if (WAY_W'(gi) == touch_way) begin
                nxt_ages[gi] = '0;
            end else if (cur_ages[gi] < touched_age) begin
                nxt_ages[gi] = cur_ages[gi] + AGE_W'(1);
            end else begin
                nxt_ages[gi] = cur_ages[gi];
            end
        end
    end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
    import lru_pkg::*;
(
    input  age_vec_t   ages,
    input  valid_vec_t valid,
    output way_t       victim
);
    logic any_empty;
    way_t empty_idx;
    way_t oldest_idx;

    always_comb begin
        any_empty  = 1'b0;
        empty_idx  = '0;
        oldest_idx = '0;
        // Scan downward so the lowest matching index wins.
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                any_empty = 1'b1;
                empty_idx = WAY_W'(w);
            end
            if (ages[w] == AGE_W'(WAYS - 1)) begin
                oldest_idx = WAY_W'(w);
            end
        end
        victim = any_empty ? empty_idx : oldest_idx;
    end
endmodule

// File: rtl/lru_state_array.sv
module lru_state_array
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  age_vec_t         wr_ages,
    input  logic [SET_W-1:0] rd_a_set,
    output age_vec_t         rd_a_ages,
    input  logic [SET_W-1:0] rd_b_set,
    output age_vec_t         rd_b_ages
);
    typedef struct packed {
        age_vec_t [NUM_SETS-1:0] ages;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ages[wr_set] = wr_ages;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                st_q.ages[s] <= reset_ages();
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_ages = st_q.ages[rd_a_set];
    assign rd_b_ages = st_q.ages[rd_b_set];
endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [1:0]       acc_way,
    input  logic [SET_W-1:0] query_set,
    input  logic [3:0]       query_valid,
    output logic [7:0]       query_age,
    output logic [1:0]       victim_way
);
    age_vec_t acc_cur_ages;
    age_vec_t acc_nxt_ages;
    age_vec_t qry_ages;

    lru_state_array #(.NUM_SETS(NUM_SETS)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_valid),
        .wr_set    (acc_set),
        .wr_ages   (acc_nxt_ages),
        .rd_a_set  (acc_set),
        .rd_a_ages (acc_cur_ages),
        .rd_b_set  (query_set),
        .rd_b_ages (qry_ages)
    );

    lru_age_update u_update (
        .cur_ages  (acc_cur_ages),
        .touch_way (acc_way),
        .nxt_ages  (acc_nxt_ages)
    );

    lru_victim_pick u_pick (
        .ages   (qry_ages),
        .valid  (query_valid),
        .victim (victim_way)
    );

    assign query_age = qry_ages;
endmodule

// File: rtl/lru_tracker_checker.sv
module lru_tracker_checker #(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic [1:0]       acc_way,
    input logic [SET_W-1:0] query_set,
    input logic [3:0]       query_valid,
    input logic [7:0]       query_age,
    input logic [1:0]       victim_way
);
    function automatic logic [1:0] age_of(input logic [7:0] v, input logic [1:0] w);
        return v[2*w +: 2];
    endfunction

    function automatic logic all_distinct(input logic [7:0] v);
        return (v[1:0] != v[3:2]) && (v[1:0] != v[5:4]) && (v[1:0] != v[7:6]) &&
               (v[3:2] != v[5:4]) && (v[3:2] != v[7:6]) && (v[5:4] != v[7:6]);
    endfunction

    function automatic logic lower_all_valid(input logic [3:0] v, input logic [1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (i < int'(w) && !v[i]) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_ages_permutation_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_distinct(query_age));

    assert_touch_to_newest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_set == query_set) |=>
        (query_set != $past(query_set)) || (age_of(query_age, $past(acc_way)) == 2'd0));

    assert_untouched_set_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_set != query_set) |=>
        (query_set != $past(query_set)) || $stable(query_age));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid) |=> (query_set != $past(query_set)) || $stable(query_age));

    assert_full_set_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&query_valid) |-> (age_of(query_age, victim_way) == 2'd3));

    assert_empty_way_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&query_valid)) |-> (!query_valid[victim_way] && lower_all_valid(query_valid, victim_way)));
endmodule

bind lru_tracker lru_tracker_checker #(.NUM_SETS(NUM_SETS)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_set     (acc_set),
    .acc_way     (acc_way),
    .query_set   (query_set),
    .query_valid (query_valid),
    .query_age   (query_age),
    .victim_way  (victim_way)
);

// File: tb/tb_lru_tracker.sv
module tb_lru_tracker;
    localparam int NS    = 4;
    localparam int SET_W = $clog2(NS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [1:0]       acc_way = '0;
    logic [SET_W-1:0] query_set = '0;
    logic [3:0]       query_valid = 4'hF;
    logic [7:0]       query_age;
    logic [1:0]       victim_way;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench model: per set, ways listed newest first.
    int order [NS][4];
    int tags  [NS][4];
    bit vld   [NS][4];

    always #5 clk = ~clk;

    lru_tracker #(.NUM_SETS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .query_set(query_set), .query_valid(query_valid),
        .query_age(query_age), .victim_way(victim_way)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_age(input int s, input int w);
        for (int i = 0; i < 4; i++) if (order[s][i] == w) return i;
        return -1;
    endfunction

    function automatic void model_touch(input int s, input int w);
        int p;
        p = model_age(s, w);
        for (int i = p; i > 0; i--) order[s][i] = order[s][i-1];
        order[s][0] = w;
    endfunction

    function automatic int exp_victim(input int s, input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (!m[i]) return i;
        return order[s][3];
    endfunction

    task automatic compare_set(input int s, input string req);
        query_set = SET_W'(s);
        #1;
        for (int w = 0; w < 4; w++) chk(req, int'(query_age[2*w +: 2]), model_age(s, w));
    endtask

    task automatic touch(input int s, input int w);
        @(negedge clk);
        acc_valid = 1'b1; acc_set = SET_W'(s); acc_way = 2'(w);
        @(negedge clk);
        acc_valid = 1'b0;
        model_touch(s, w);
    endtask

    task automatic cache_access(input int s, input int tag, output bit hit);
        logic [3:0] m;
        int w;
        hit = 0;
        for (int i = 0; i < 4; i++) if (vld[s][i] && tags[s][i] == tag) begin hit = 1; w = i; end
        if (!hit) begin
            for (int i = 0; i < 4; i++) m[i] = vld[s][i];
            query_set = SET_W'(s); query_valid = m;
            #1;
            chk("R6 R7 victim", int'(victim_way), exp_victim(s, m));
            w = int'(victim_way);
            tags[s][w] = tag; vld[s][w] = 1;
        end
        touch(s, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit hit;
        int hits, pos_a, oldw, olds, w, s, o;
        logic [15:0] lfsr;
        for (int i = 0; i < NS; i++)
            for (int j = 0; j < 4; j++) begin order[i][j] = j; vld[i][j] = 0; tags[i][j] = -1; end

        // R1: reset state, checked during and after reset
        repeat (3) @(negedge clk);
        for (int i = 0; i < NS; i++) compare_set(i, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NS; i++) compare_set(i, "R1 after reset");

        // R10: named sequence in set 1
        cache_access(1, 10, hit); cache_access(1, 12, hit);
        cache_access(1, 11, hit); cache_access(1, 13, hit);
        pos_a = -1;
        for (int i = 0; i < 4; i++) if (tags[1][i] == 10) pos_a = i;
        cache_access(1, 14, hit);
        chk("R10 E takes A way", (tags[1][pos_a] == 14) ? 1 : 0, 1);
        cache_access(1, 11, hit);
        chk("R10 B hit", int'(hit), 1);
        query_set = 2'd1; #1;
        for (int i = 0; i < 4; i++) begin
            if (tags[1][i] == 11) chk("R10 B newest", int'(query_age[2*i +: 2]), 0);
            if (tags[1][i] == 14) chk("R10 E second", int'(query_age[2*i +: 2]), 1);
        end
        compare_set(1, "R10 order");

        // R11: cycle five blocks through set 2
        hits = 0;
        for (int r = 0; r < 4; r++)
            for (int b = 0; b < 5; b++) begin
                cache_access(2, 100 + b, hit);
                hits += int'(hit);
            end
        chk("R11 zero hits", hits, 0);

        // R6/R7: all sixteen valid masks on set 1
        for (int m = 0; m < 16; m++) begin
            query_set = 2'd1; query_valid = 4'(m);
            #1;
            chk(m == 15 ? "R6 oldest" : "R7 lowest empty", int'(victim_way), exp_victim(1, 4'(m)));
        end
        query_valid = 4'hF;

        // R2/R3/R4/R8: pseudo-random touches with full per-way checks
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[1:0]); w = int'(lfsr[3:2]);
            o = (s + 1 + int'(lfsr[5:4]) % 3) % NS;
            olds = 0;
            for (int i = 0; i < 4; i++) tags[0][i] = model_age(s, i);
            oldw = model_age(s, w);
            query_set = SET_W'(o);
            touch(s, w);
            for (int i = 0; i < 4; i++)
                chk("R8 other set", int'(query_age[2*i +: 2]), model_age(o, i));
            query_set = SET_W'(s); #1;
            for (int i = 0; i < 4; i++) begin
                if (i == w) chk("R2 touched", int'(query_age[2*i +: 2]), 0);
                else if (tags[0][i] < oldw) chk("R3 aged", int'(query_age[2*i +: 2]), tags[0][i] + 1);
                else chk("R4 kept", int'(query_age[2*i +: 2]), tags[0][i]);
                olds += int'(query_age[2*i +: 2]);
            end
            chk("R5 permutation sum", olds, 6);
        end

        // R9: idle cycles change nothing
        repeat (5) @(negedge clk);
        for (int i = 0; i < NS; i++) compare_set(i, "R9 idle");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule